// File: doc/BRIEF.md
# Compare-Match Timer with Periodic Re-Arm

This block is a 64-bit up-counter paired with a 64-bit compare value. When comparison is enabled and the count becomes equal to the compare value, a sticky event flag is set, and an interrupt line follows that flag whenever interrupts are enabled. In one-shot operation the compare value is left alone after a match, and software moves it forward. In periodic operation the hardware adds a programmed step to the compare value on every match, so events recur without software help.

Software reaches the block through a single-cycle register port: a write strobe, a small address, 32-bit write data and combinational read data. The flag is set on the first cycle of a match, not on the level of equality. An interrupt handler may therefore clear the flag and move the compare value in either order and still see exactly one request per match.

Top module: `cmp_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: While control bit 0 is 1 the counter increases by one per cycle, with the carry passing from the low half into the high half. While control bit 0 is 0 the counter holds.
- R3: While control bit 1 is 1, the flag is set in the cycle after the counter first equals the compare value. While control bit 1 is 0, the flag is never set.
- R4: `irq` is high exactly when the flag is 1 and control bit 2 is 1. With bit 2 at 0 the flag still sets and reads back as 1.
- R5: With control bit 3 at 1 (periodic), each match adds the 32-bit step register, zero-extended, to the compare value. A software write to the compare value in the same cycle takes priority.
- R6: With control bit 3 at 0 (one-shot), a match leaves the compare value unchanged.
- R7: The flag sets only when equality begins. If the flag is cleared while the counter still equals the compare value, it stays clear. Each match gives exactly one rising edge of `irq`, whether the handler clears the flag before or after it raises the compare value.
- R8: Writing a value with bit 0 at 1 to the flag register clears the flag. Writing 0 has no effect. When a new match and a clear fall in the same cycle, the flag ends up set.
- R9: Writes to the counter take effect only while control bit 0 is 0, and are ignored while counting.
- R10: Register map, 3-bit address: 0 counter low, 1 counter high, 2 control in bits 3:0, 3 flag in bit 0, 4 compare low, 5 compare high, 6 step. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| addr | input | 3 | Register address for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two events can fall in the same cycle: a software clear of the flag and a new match that sets it. The bench provokes this in periodic mode with a step of 3 by holding a clear write on the flag register for many cycles in a row, so that every match lands on a clear. Each match must still give exactly one `irq` pulse, and the number of pulses must equal the compare advance divided by the step. A second contest, a flag clear while equality still holds, is run with the counter stopped in both handler orderings and judged by counting `irq` rising edges.

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * BUS_W;

  localparam logic [ADDR_W-1:0] A_CNT_LO = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CNT_HI = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_FLAG   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CMP_LO = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_CMP_HI = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_STEP   = ADDR_W'(6);

  logic [3:0]       ctrl;
  logic [CNT_W-1:0] cnt, cmp;
  logic [BUS_W-1:0] step;
  logic             flag, match_q;

  wire run      = ctrl[0];
  wire cmp_on   = ctrl[1];
  wire irq_on   = ctrl[2];
  wire periodic = ctrl[3];

  wire wr_cnt_lo = wr_en && addr == A_CNT_LO;
  wire wr_cnt_hi = wr_en && addr == A_CNT_HI;
  wire wr_ctrl   = wr_en && addr == A_CTRL;
  wire wr_flag   = wr_en && addr == A_FLAG;
  wire wr_cmp_lo = wr_en && addr == A_CMP_LO;
  wire wr_cmp_hi = wr_en && addr == A_CMP_HI;
  wire wr_step   = wr_en && addr == A_STEP;

  wire match = cmp_on && (cnt == cmp);
  wire hit   = match && !match_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      cnt     <= '0;
      cmp     <= '0;
      step    <= '0;
      flag    <= 1'b0;
      match_q <= 1'b0;
    end else begin
      match_q <= match;
      if (wr_ctrl) ctrl <= wdata[3:0];
      if (wr_step) step <= wdata;

      if (run) cnt <= cnt + 1'b1;
      else begin
        if (wr_cnt_lo) cnt[BUS_W-1:0]     <= wdata;
        if (wr_cnt_hi) cnt[CNT_W-1:BUS_W] <= wdata;
      end

      if (wr_cmp_lo || wr_cmp_hi) begin
        if (wr_cmp_lo) cmp[BUS_W-1:0]     <= wdata;
        if (wr_cmp_hi) cmp[CNT_W-1:BUS_W] <= wdata;
      end else if (hit && periodic) begin
        cmp <= cmp + CNT_W'(step);
      end

      if (hit) flag <= 1'b1;
      else if (wr_flag && wdata[0]) flag <= 1'b0;
    end
  end

  assign irq = flag && irq_on;

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = cnt[BUS_W-1:0];
      A_CNT_HI: rdata = cnt[CNT_W-1:BUS_W];
      A_CTRL:   rdata = BUS_W'(ctrl);
      A_FLAG:   rdata = BUS_W'(flag);
      A_CMP_LO: rdata = cmp[BUS_W-1:0];
      A_CMP_HI: rdata = cmp[CNT_W-1:BUS_W];
      A_STEP:   rdata = step;
      default:  rdata = '0;
    endcase
  end

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> cnt == $past(cnt) + 1'b1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_cnt_lo && !wr_cnt_hi) |=> $stable(cnt));

  p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (match && !match_q) |=> flag);

  p_no_match_no_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_on |=> !$rose(flag));

  p_periodic_advance_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && periodic && !wr_cmp_lo && !wr_cmp_hi) |=> cmp == $past(cmp) + CNT_W'($past(step)));

  p_oneshot_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !periodic && !wr_cmp_lo && !wr_cmp_hi) |=> $stable(cmp));

  p_level_no_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (match && match_q) |=> !$rose(flag));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_flag && wdata[0] && !match) |=> !flag);
endmodule

// File: tb/cmp_timer_bench.sv
`timescale 1ns/1ps
module cmp_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0, errors = 0, cycles = 0, rises = 0;
  bit irq_prev = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmp_timer u_cmp_timer (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                         .wdata(wdata), .rdata(rdata), .irq(irq));

  logic [63:0] m_cnt, m_cmp;
  logic [31:0] m_step;
  logic [3:0]  m_ctrl;
  bit m_flag, m_eq_prev;

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0: return m_cnt[31:0];
      3'd1: return m_cnt[63:32];
      3'd2: return {28'd0, m_ctrl};
      3'd3: return {31'd0, m_flag};
      3'd4: return m_cmp[31:0];
      3'd5: return m_cmp[63:32];
      3'd6: return m_step;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_cmp = 0; m_step = 0; m_ctrl = 0; m_flag = 0; m_eq_prev = 0;
    end else begin
      bit eq, fresh;
      logic [63:0] n_cnt, n_cmp;
      eq = m_ctrl[1] && (m_cnt == m_cmp);
      fresh = eq && !m_eq_prev;
      n_cnt = m_cnt;
      n_cmp = m_cmp;
      if (m_ctrl[0]) n_cnt = m_cnt + 64'd1;
      else if (wr_en && addr == 3'd0) n_cnt[31:0] = wdata;
      else if (wr_en && addr == 3'd1) n_cnt[63:32] = wdata;
      if (wr_en && addr == 3'd4) n_cmp[31:0] = wdata;
      else if (wr_en && addr == 3'd5) n_cmp[63:32] = wdata;
      else if (fresh && m_ctrl[3]) n_cmp = m_cmp + {32'd0, m_step};
      if (fresh) m_flag = 1;
      else if (wr_en && addr == 3'd3 && wdata[0]) m_flag = 0;
      if (wr_en && addr == 3'd2) m_ctrl = wdata[3:0];
      if (wr_en && addr == 3'd6) m_step = wdata;
      m_cnt = n_cnt;
      m_cmp = n_cmp;
      m_eq_prev = eq;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      #1;
      check("R4 irq", irq, m_flag && m_ctrl[2]);
      check("R10 rdata", rdata, m_read(addr));
      if (irq && !irq_prev) rises++;
      irq_prev = irq;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected below 100000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, lo, hi;
    int r0, k;
    repeat (3) @(negedge clk);
    rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1 reset register", v, 0);
    end
    check("R1 reset irq", irq, 0);

    // R2 carry across halves
    wr(3'd0, 32'hFFFF_FFFE);
    wr(3'd2, 32'h1);
    idle(4);
    wr(3'd2, 32'h0);
    rd(3'd1, hi);
    check("R2 carry into high half", hi, 1);
    rd(3'd0, lo);
    check("R2 count value", {hi, lo}, m_cnt);

    // R9 write while counting is ignored
    wr(3'd2, 32'h1);
    wr(3'd1, 32'h55);
    wr(3'd2, 32'h0);
    rd(3'd1, hi);
    check("R9 write ignored while counting", hi, 1);
    wr(3'd1, 32'h0);
    wr(3'd0, 32'd50);
    rd(3'd0, lo);
    check("R9 write accepted while stopped", lo, 50);

    // R7 order A: clear while still equal, then raise compare
    wr(3'd4, 32'd50);
    r0 = rises;
    wr(3'd2, 32'h6);
    idle(2);
    rd(3'd3, v);
    check("R3 flag set on match", v, 1);
    check("R4 irq raised", irq, 1);
    wr(3'd3, 32'h1);
    idle(3);
    rd(3'd3, v);
    check("R7 clear holds while equal", v, 0);
    wr(3'd4, 32'd80);
    idle(3);
    check("R7 order A one edge", rises - r0, 1);

    // R7 order B: raise compare first, then clear
    r0 = rises;
    wr(3'd4, 32'd50);
    idle(2);
    rd(3'd3, v);
    check("R3 flag set on new equality", v, 1);
    wr(3'd4, 32'd90);
    wr(3'd3, 32'h1);
    idle(3);
    rd(3'd3, v);
    check("R7 order B flag clear", v, 0);
    check("R7 order B one edge", rises - r0, 1);

    // R8 write 0 has no effect
    wr(3'd4, 32'd50);
    idle(2);
    wr(3'd3, 32'h0);
    rd(3'd3, v);
    check("R8 write zero keeps flag", v, 1);
    wr(3'd3, 32'h1);

    // R4 irq disabled, flag still visible
    wr(3'd2, 32'h0);
    wr(3'd4, 32'd60);
    wr(3'd0, 32'd60);
    wr(3'd2, 32'h2);
    idle(2);
    rd(3'd3, v);
    check("R4 flag set with irq off", v, 1);
    check("R4 irq low when disabled", irq, 0);
    wr(3'd3, 32'h1);

    // R3 comparison disabled never sets flag
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd5);
    wr(3'd2, 32'h5);
    idle(12);
    rd(3'd3, v);
    check("R3 no flag when compare off", v, 0);

    // R6 one-shot keeps compare while counting past it
    wr(3'd2, 32'h0);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd8);
    r0 = rises;
    wr(3'd2, 32'h7);
    idle(20);
    rd(3'd4, v);
    check("R6 compare unchanged", v, 8);
    check("R6 single edge", rises - r0, 1);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h1);

    // R5 periodic with handler clearing
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd10);
    wr(3'd6, 32'd7);
    r0 = rises;
    wr(3'd2, 32'hF);
    for (int i = 0; i < 30; i++) begin
      if (irq) wr(3'd3, 32'h1); else idle(1);
    end
    wr(3'd2, 32'h0);
    rd(3'd4, v);
    k = (int'(v) - 10) / 7;
    check("R5 compare advanced by step multiples", (v - 10) % 7, 0);
    check("R5 several periods", k > 2, 1);
    check("R5 one edge per period", rises - r0, k);
    wr(3'd3, 32'h1);

    // R8 clear colliding with new match each period
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd3);
    wr(3'd6, 32'd3);
    r0 = rises;
    wr(3'd2, 32'hF);
    @(negedge clk); wr_en = 1; addr = 3'd3; wdata = 32'h1;
    repeat (20) @(negedge clk);
    wr_en = 0;
    wr(3'd2, 32'h0);
    rd(3'd4, v);
    k = (int'(v) - 3) / 3;
    check("R8 matches occurred", k > 4, 1);
    check("R8 match wins over clear", rises - r0, k);

    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule